// File: doc/BRIEF.md
# Age-Ordered Issue Queue Selector

This block is a small out-of-order issue queue. Each dispatched micro-op carries a sequence number, an operation class, a thread id, a source tag it may wait on, and a flag marking it non-speculative. A micro-op becomes issuable once its source tag is broadcast on the wakeup port and, if non-speculative, once a release naming its sequence number arrives. Every cycle the selector first takes the oldest issuable entry inside each operation class. It then compares only those class heads and issues the globally oldest. It repeats this for each of the fixed number of issue slots.

Issued entries keep their slot until a commit for their thread retires them. Commit frees every entry of one thread at or below a sequence number. A squash frees every entry of one thread above a sequence number, and it stops such entries from issuing in that same cycle. Dispatch is accepted only while both the whole queue and the dispatching thread have room. Total and per-thread free counts and full flags are reported to the dispatch stage.

Top module: `iq_age_select`

## Requirements
- R1: After reset no issue slot is valid, `free_total` is 8, `full_total` is 0, and each thread's free count is 6 with its full flag low.
- R2: Sequence numbers are compared as plain unsigned 8-bit values, and a smaller number is older. In any cycle, slot 0 carries the oldest issuable entry and slot 1 the next oldest, regardless of class. Slot 1 is valid only when slot 0 is. No more than 2 ops issue per cycle.
- R3: Each issue slot `s` reports the entry's sequence number on `iss_seq[s*8 +: 8]`, its class (0, 1 or 2) on `iss_cls[s*2 +: 2]` and its thread on `iss_tid[s]`.
- R4: An entry dispatched with `disp_src_rdy` = 1 can issue in the cycle after dispatch. An entry dispatched with `disp_src_rdy` = 0 issues no earlier than the cycle after a wakeup with a matching thread and tag. A wakeup for another thread has no effect on it.
- R5: A non-speculative entry does not issue while ready until a release with its own thread and sequence number is seen. It is issuable from the next cycle. A release naming another sequence number has no effect.
- R6: An entry issues exactly once. It keeps its slot until a commit for its thread with a sequence number at or above its own.
- R7: A squash for a thread removes that thread's entries whose sequence number is greater than `sq_seq`. Such an entry is not issued in the squash cycle. Entries of the other thread and older entries are kept.
- R8: `disp_accept` is high only when `disp_valid` is high, the queue holds fewer than 8 entries, and the dispatching thread holds fewer than 6. `thr_free[t*4 +: 4]` equals 6 minus thread t's occupancy. `thr_full[t]` is set at 6 entries, and `full_total` is set at 8.
- R9: Entries freed by commit or squash are counted free, and can be reused by dispatch, in the cycle after the commit or squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | 8 | Sequence number of dispatched op |
| disp_cls | input | 2 | Operation class of dispatched op |
| disp_tid | input | 1 | Thread of dispatched op |
| disp_nonspec | input | 1 | Op must wait for a release |
| disp_src_rdy | input | 1 | Source operand already available |
| disp_src_tag | input | 8 | Tag the op waits on when not ready |
| disp_accept | output | 1 | Dispatch taken this cycle |
| wake_valid | input | 1 | Wakeup broadcast |
| wake_tid | input | 1 | Thread of wakeup |
| wake_tag | input | 8 | Tag being woken |
| rel_valid | input | 1 | Non-speculative release |
| rel_tid | input | 1 | Thread of release |
| rel_seq | input | 8 | Sequence number released |
| cmt_valid | input | 1 | Commit request |
| cmt_tid | input | 1 | Thread committing |
| cmt_seq | input | 8 | Commit through this number |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | 1 | Thread squashed |
| sq_seq | input | 8 | Entries above this number are removed |
| iss_valid | output | 2 | Per-slot issue valid |
| iss_seq | output | 16 | Per-slot sequence number |
| iss_cls | output | 4 | Per-slot class |
| iss_tid | output | 2 | Per-slot thread |
| free_total | output | 4 | Free entries in the queue |
| full_total | output | 1 | Queue full |
| thr_free | output | 8 | Per-thread free count |
| thr_full | output | 2 | Per-thread full flag |

## Verification
Issue outputs are combinational from registered state. A ready op dispatched in cycle c is therefore due on the slots in cycle c+1. After a wakeup or release in cycle c, the issuable ops appear two per cycle from c+1, oldest first. Count changes from commit, squash or dispatch show one cycle after the request. A squash or a kill is seen in the request cycle itself. The driver stores each expected issue with its due cycle in a scoreboard. The monitor samples on the falling edge and compares the sequence number, class, thread and cycle in order. Any issue that was not expected counts as a failure.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int SEQ_W = 8;
  localparam int CLS_W = 2;
  localparam int TID_W = 1;

  typedef logic [SEQ_W-1:0] seq_t;

  typedef struct packed {
    seq_t             seq;
    logic [CLS_W-1:0] cls;
    logic [TID_W-1:0] tid;
    logic             nonspec;
    logic             src_rdy;
    seq_t             src_tag;
  } uop_t;

  // smaller sequence number is older
  function automatic logic seq_older(seq_t a, seq_t b);
    return a < b;
  endfunction
endpackage

// File: rtl/iq_entries.sv
module iq_entries
  import iq_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  uop_t                    wr_uop,
  input  logic                    wake_valid,
  input  logic [TID_W-1:0]        wake_tid,
  input  seq_t                    wake_tag,
  input  logic                    rel_valid,
  input  logic [TID_W-1:0]        rel_tid,
  input  seq_t                    rel_seq,
  input  logic [ENTRIES-1:0]      kill,
  input  logic [ENTRIES-1:0]      grant,
  output logic [ENTRIES-1:0]      valid_o,
  output uop_t [ENTRIES-1:0]      uop_o,
  output logic [ENTRIES-1:0]      rdy_o,
  output logic [ENTRIES-1:0]      rel_o,
  output logic [ENTRIES-1:0]      issued_o
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] rdy_q, rdy_d;
  logic [ENTRIES-1:0] rel_q, rel_d;
  logic [ENTRIES-1:0] iss_q, iss_d;
  uop_t [ENTRIES-1:0] uop_q;
  logic               wr_woken;

  assign wr_woken = wake_valid && (wr_uop.tid == wake_tid) && (wr_uop.src_tag == wake_tag);

  always_comb begin
    valid_d = valid_q & ~kill;
    rdy_d   = rdy_q;
    rel_d   = rel_q;
    iss_d   = iss_q | grant;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wake_valid && (uop_q[i].tid == wake_tid) && (uop_q[i].src_tag == wake_tag))
        rdy_d[i] = 1'b1;
      if (rel_valid && uop_q[i].nonspec && (uop_q[i].tid == rel_tid) && (uop_q[i].seq == rel_seq))
        rel_d[i] = 1'b1;
    end
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      rdy_d[wr_idx]   = wr_uop.src_rdy | wr_woken;
      rel_d[wr_idx]   = 1'b0;
      iss_d[wr_idx]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rdy_q   <= '0;
      rel_q   <= '0;
      iss_q   <= '0;
    end else begin
      valid_q <= valid_d;
      rdy_q   <= rdy_d;
      rel_q   <= rel_d;
      iss_q   <= iss_d;
    end
  end

  // payload: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) uop_q[wr_idx] <= wr_uop;
  end

  assign valid_o  = valid_q;
  assign uop_o    = uop_q;
  assign rdy_o    = rdy_q;
  assign rel_o    = rel_q;
  assign issued_o = iss_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R6: the selector never grants an entry a second time
    a_r6_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> (valid_q[g] && !iss_q[g]));
    // R6: an issued entry stays issued until it leaves the queue
    a_r6_issued_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] && !kill[g]) |=> (valid_q[g] && iss_q[g]));
  end
endmodule

// File: rtl/iq_class_head.sv
module iq_class_head
  import iq_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] elig,
  input  seq_t [ENTRIES-1:0] seqs,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output seq_t               seq
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    seq   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (elig[i] && (!found || seq_older(seqs[i], seq))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        seq   = seqs[i];
      end
    end
  end
endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick
  import iq_pkg::*;
#(
  parameter int NCLASS  = 3,
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [NCLASS-1:0]            hv,
  input  seq_t [NCLASS-1:0]            hseq,
  input  logic [NCLASS-1:0][IDX_W-1:0] hidx,
  output logic                         win_v,
  output logic [IDX_W-1:0]             win_idx,
  output seq_t                         win_seq,
  output logic [CLS_W-1:0]             win_cls
);
  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    win_seq = '0;
    win_cls = '0;
    for (int c = 0; c < NCLASS; c++) begin
      if (hv[c] && (!win_v || seq_older(hseq[c], win_seq))) begin
        win_v   = 1'b1;
        win_idx = hidx[c];
        win_seq = hseq[c];
        win_cls = CLS_W'(c);
      end
    end
  end
endmodule

// File: rtl/iq_occupancy.sv
module iq_occupancy
  import iq_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int THREADS   = 2,
  parameter int THR_LIMIT = 6,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            add,
  input  logic [TID_W-1:0]                add_tid,
  input  logic [ENTRIES-1:0]              valid_q,
  input  logic [ENTRIES-1:0][TID_W-1:0]   tids,
  input  logic [ENTRIES-1:0]              kill,
  output logic [CNT_W-1:0]                free_total,
  output logic                            full_total,
  output logic [THREADS-1:0][CNT_W-1:0]   thr_free,
  output logic [THREADS-1:0]              thr_full
);
  logic [CNT_W-1:0]              cnt_q, cnt_d, dec;
  logic [THREADS-1:0][CNT_W-1:0] tcnt_q, tcnt_d, tdec;

  always_comb begin
    dec  = '0;
    tdec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (kill[i] && valid_q[i]) begin
        dec = dec + CNT_W'(1);
        for (int t = 0; t < THREADS; t++)
          if (tids[i] == TID_W'(t)) tdec[t] = tdec[t] + CNT_W'(1);
      end
    end
    cnt_d = cnt_q + CNT_W'(add) - dec;
    for (int t = 0; t < THREADS; t++)
      tcnt_d[t] = tcnt_q[t] + CNT_W'(add && (add_tid == TID_W'(t))) - tdec[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign free_total = CNT_W'(ENTRIES) - cnt_q;
  assign full_total = (cnt_q == CNT_W'(ENTRIES));
  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    assign thr_free[t] = CNT_W'(THR_LIMIT) - tcnt_q[t];
    assign thr_full[t] = (tcnt_q[t] >= CNT_W'(THR_LIMIT));
    // R8: a thread never holds more than its limit
    a_r8_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt_q[t] <= CNT_W'(THR_LIMIT));
  end

  // R8/R9: the running count matches the valid entries held by storage
  a_r9_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'($countones(valid_q)));
endmodule

// File: rtl/iq_age_select.sv
module iq_age_select
  import iq_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int NCLASS    = 3,
  parameter int ISSUE_W   = 2,
  parameter int THREADS   = 2,
  parameter int THR_LIMIT = 6,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  input  logic [SEQ_W-1:0]           disp_seq,
  input  logic [CLS_W-1:0]           disp_cls,
  input  logic [TID_W-1:0]           disp_tid,
  input  logic                       disp_nonspec,
  input  logic                       disp_src_rdy,
  input  logic [SEQ_W-1:0]           disp_src_tag,
  output logic                       disp_accept,
  input  logic                       wake_valid,
  input  logic [TID_W-1:0]           wake_tid,
  input  logic [SEQ_W-1:0]           wake_tag,
  input  logic                       rel_valid,
  input  logic [TID_W-1:0]           rel_tid,
  input  logic [SEQ_W-1:0]           rel_seq,
  input  logic                       cmt_valid,
  input  logic [TID_W-1:0]           cmt_tid,
  input  logic [SEQ_W-1:0]           cmt_seq,
  input  logic                       sq_valid,
  input  logic [TID_W-1:0]           sq_tid,
  input  logic [SEQ_W-1:0]           sq_seq,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*SEQ_W-1:0]   iss_seq,
  output logic [ISSUE_W*CLS_W-1:0]   iss_cls,
  output logic [ISSUE_W*TID_W-1:0]   iss_tid,
  output logic [CNT_W-1:0]           free_total,
  output logic                       full_total,
  output logic [THREADS*CNT_W-1:0]   thr_free,
  output logic [THREADS-1:0]         thr_full
);
  logic [ENTRIES-1:0]            valid_q, rdy_q, rel_q, issued_q;
  uop_t [ENTRIES-1:0]            uop_q;
  seq_t [ENTRIES-1:0]            seq_vec;
  logic [ENTRIES-1:0][TID_W-1:0] tid_vec;
  logic [ENTRIES-1:0]            kill, elig, grant;
  logic [IDX_W-1:0]              alloc_idx;
  logic                          alloc_ok;
  uop_t                          wr_uop;
  logic [THREADS-1:0][CNT_W-1:0] thr_free_w;

  logic [ENTRIES-1:0]            mask    [ISSUE_W+1];
  logic                          win_v   [ISSUE_W];
  logic [IDX_W-1:0]              win_idx [ISSUE_W];
  seq_t                          win_seq [ISSUE_W];
  logic [CLS_W-1:0]              win_cls [ISSUE_W];

  // ---- allocation: lowest free slot ----
  always_comb begin
    alloc_idx = '0;
    alloc_ok  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !alloc_ok) begin
        alloc_idx = IDX_W'(i);
        alloc_ok  = 1'b1;
      end
    end
  end

  assign disp_accept = disp_valid && alloc_ok && !full_total && !thr_full[disp_tid];

  always_comb begin
    wr_uop.seq     = disp_seq;
    wr_uop.cls     = disp_cls;
    wr_uop.tid     = disp_tid;
    wr_uop.nonspec = disp_nonspec;
    wr_uop.src_rdy = disp_src_rdy;
    wr_uop.src_tag = disp_src_tag;
  end

  // ---- removal by commit and squash, and base eligibility ----
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      seq_vec[i] = uop_q[i].seq;
      tid_vec[i] = uop_q[i].tid;
      kill[i] = valid_q[i] &&
                ((cmt_valid && (uop_q[i].tid == cmt_tid) && !seq_older(cmt_seq, uop_q[i].seq)) ||
                 (sq_valid  && (uop_q[i].tid == sq_tid)  &&  seq_older(sq_seq,  uop_q[i].seq)));
      elig[i] = valid_q[i] && rdy_q[i] && !issued_q[i] && !kill[i] &&
                (!uop_q[i].nonspec || rel_q[i]);
    end
  end

  iq_entries #(.ENTRIES(ENTRIES)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (disp_accept),
    .wr_idx     (alloc_idx),
    .wr_uop     (wr_uop),
    .wake_valid (wake_valid),
    .wake_tid   (wake_tid),
    .wake_tag   (wake_tag),
    .rel_valid  (rel_valid),
    .rel_tid    (rel_tid),
    .rel_seq    (rel_seq),
    .kill       (kill),
    .grant      (grant),
    .valid_o    (valid_q),
    .uop_o      (uop_q),
    .rdy_o      (rdy_q),
    .rel_o      (rel_q),
    .issued_o   (issued_q)
  );

  // ---- select: per-slot class heads, then global age pick ----
  assign mask[0] = elig;

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    logic [NCLASS-1:0]            hv;
    seq_t [NCLASS-1:0]            hseq;
    logic [NCLASS-1:0][IDX_W-1:0] hidx;

    for (genvar c = 0; c < NCLASS; c++) begin : g_cls
      logic [ENTRIES-1:0] cls_elig;
      always_comb begin
        for (int i = 0; i < ENTRIES; i++)
          cls_elig[i] = mask[s][i] && (uop_q[i].cls == CLS_W'(c));
      end
      iq_class_head #(.ENTRIES(ENTRIES)) u_head (
        .elig  (cls_elig),
        .seqs  (seq_vec),
        .found (hv[c]),
        .idx   (hidx[c]),
        .seq   (hseq[c])
      );
    end

    iq_age_pick #(.NCLASS(NCLASS), .ENTRIES(ENTRIES)) u_pick (
      .hv      (hv),
      .hseq    (hseq),
      .hidx    (hidx),
      .win_v   (win_v[s]),
      .win_idx (win_idx[s]),
      .win_seq (win_seq[s]),
      .win_cls (win_cls[s])
    );

    assign mask[s+1] = mask[s] & ~({{(ENTRIES-1){1'b0}}, win_v[s]} << win_idx[s]);

    assign iss_valid[s]                 = win_v[s];
    assign iss_seq[s*SEQ_W +: SEQ_W]    = win_seq[s];
    assign iss_cls[s*CLS_W +: CLS_W]    = win_cls[s];
    assign iss_tid[s*TID_W +: TID_W]    = uop_q[win_idx[s]].tid;

    // R7: a slot never carries an entry that the current squash removes
    a_r7_squash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && iss_valid[s] && (iss_tid[s*TID_W +: TID_W] == sq_tid))
        |-> !seq_older(sq_seq, iss_seq[s*SEQ_W +: SEQ_W]));
    // R6: a slot never carries an entry that the current commit retires
    a_r6_commit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && iss_valid[s] && (iss_tid[s*TID_W +: TID_W] == cmt_tid))
        |-> seq_older(cmt_seq, iss_seq[s*SEQ_W +: SEQ_W]));
    if (s > 0) begin : g_order
      // R2: later slots are younger and only used behind earlier ones
      a_r2_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[s] |-> (iss_valid[s-1] &&
          seq_older(iss_seq[(s-1)*SEQ_W +: SEQ_W], iss_seq[s*SEQ_W +: SEQ_W])));
    end
  end

  always_comb begin
    grant = '0;
    for (int s = 0; s < ISSUE_W; s++)
      if (win_v[s]) grant[win_idx[s]] = 1'b1;
  end

  // ---- occupancy ----
  iq_occupancy #(.ENTRIES(ENTRIES), .THREADS(THREADS), .THR_LIMIT(THR_LIMIT)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .add        (disp_accept),
    .add_tid    (disp_tid),
    .valid_q    (valid_q),
    .tids       (tid_vec),
    .kill       (kill),
    .free_total (free_total),
    .full_total (full_total),
    .thr_free   (thr_free_w),
    .thr_full   (thr_full)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_tf
    assign thr_free[t*CNT_W +: CNT_W] = thr_free_w[t];
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_gchk
    // R4: only entries with a ready source are granted
    a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> rdy_q[g]);
    // R5: a non-speculative entry is granted only after its release
    a_r5_nonspec_held: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] && uop_q[g].nonspec) |-> rel_q[g]);
  end

  // R8: a full queue refuses dispatch
  a_r8_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    full_total |-> !disp_accept);
endmodule

// File: tb/iq_age_select_test.sv
module iq_age_select_test;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic       disp_valid, disp_nonspec, disp_src_rdy, disp_accept;
  logic [7:0] disp_seq, disp_src_tag;
  logic [1:0] disp_cls;
  logic       disp_tid;
  logic       wake_valid, wake_tid, rel_valid, rel_tid, cmt_valid, cmt_tid, sq_valid, sq_tid;
  logic [7:0] wake_tag, rel_seq, cmt_seq, sq_seq;
  logic [1:0] iss_valid, iss_tid;
  logic [15:0] iss_seq;
  logic [3:0] iss_cls;
  logic [3:0] free_total;
  logic       full_total;
  logic [7:0] thr_free;
  logic [1:0] thr_full;

  iq_age_select uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_seq(disp_seq), .disp_cls(disp_cls), .disp_tid(disp_tid),
    .disp_nonspec(disp_nonspec), .disp_src_rdy(disp_src_rdy), .disp_src_tag(disp_src_tag),
    .disp_accept(disp_accept),
    .wake_valid(wake_valid), .wake_tid(wake_tid), .wake_tag(wake_tag),
    .rel_valid(rel_valid), .rel_tid(rel_tid), .rel_seq(rel_seq),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls), .iss_tid(iss_tid),
    .free_total(free_total), .full_total(full_total), .thr_free(thr_free), .thr_full(thr_full)
  );

  typedef struct { int seq; int cls; int tid; int cyc; } item_t;
  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_iss(input int s, input int c, input int t, input int due);
    item_t it;
    it.seq = s; it.cls = c; it.tid = t; it.cyc = due;
    sb.push_back(it);
  endtask

  task automatic clear_in();
    disp_valid = 0; disp_seq = 0; disp_cls = 0; disp_tid = 0; disp_nonspec = 0;
    disp_src_rdy = 0; disp_src_tag = 0;
    wake_valid = 0; wake_tid = 0; wake_tag = 0;
    rel_valid = 0; rel_tid = 0; rel_seq = 0;
    cmt_valid = 0; cmt_tid = 0; cmt_seq = 0;
    sq_valid = 0; sq_tid = 0; sq_seq = 0;
  endtask

  task automatic slot();
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic set_disp(input int s, input int c, input int t, input bit ns, input bit rdy, input int tag);
    disp_valid = 1; disp_seq = 8'(s); disp_cls = 2'(c); disp_tid = t[0];
    disp_nonspec = ns; disp_src_rdy = rdy; disp_src_tag = 8'(tag);
  endtask

  task automatic dispatch(input int s, input int c, input int t, input bit ns, input bit rdy,
                          input int tag, input bit acc);
    slot();
    set_disp(s, c, t, ns, rdy, tag);
    @(negedge clk);
    chk("R8 disp_accept", int'(disp_accept), int'(acc));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot();
  endtask

  // monitor: pops scoreboard items in slot order as issues appear
  always @(negedge clk) begin
    if (mon_on) begin
      for (int s = 0; s < 2; s++) begin
        if (iss_valid[s]) begin
          if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 unexpected issue actual=%0d expected=none (cycle %0d)",
                     iss_seq[s*8 +: 8], cyc);
          end else begin
            item_t e;
            e = sb.pop_front();
            chk("R2 issue seq", int'(iss_seq[s*8 +: 8]), e.seq);
            chk("R3 issue cls", int'(iss_cls[s*2 +: 2]), e.cls);
            chk("R3 issue tid", int'(iss_tid[s]), e.tid);
            chk("R4 issue cycle", cyc, e.cyc);
          end
        end
      end
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 iss_valid", int'(iss_valid), 0);
    chk("R1 free_total", int'(free_total), 8);
    chk("R1 full_total", int'(full_total), 0);
    chk("R1 thr_free0", int'(thr_free[3:0]), 6);
    chk("R1 thr_free1", int'(thr_free[7:4]), 6);
    chk("R1 thr_full", int'(thr_full), 0);
    mon_on = 1;

    // R2/R4: cross-class oldest-first after one wakeup; other thread stays
    dispatch(9, 2, 0, 0, 0, 50, 1);
    dispatch(6, 0, 0, 0, 0, 50, 1);
    dispatch(8, 1, 0, 0, 0, 50, 1);
    dispatch(7, 1, 0, 0, 0, 50, 1);
    dispatch(10, 0, 0, 0, 0, 50, 1);
    dispatch(11, 1, 1, 0, 0, 50, 1);
    slot();
    wake_valid = 1; wake_tid = 0; wake_tag = 50;
    expect_iss(6, 0, 0, cyc + 1);
    expect_iss(7, 1, 0, cyc + 1);
    expect_iss(8, 1, 0, cyc + 2);
    expect_iss(9, 2, 0, cyc + 2);
    expect_iss(10, 0, 0, cyc + 3);
    idle(5);
    @(negedge clk);
    chk("R6 free after issue", int'(free_total), 2);
    // R6 commit frees through seq
    slot(); cmt_valid = 1; cmt_tid = 0; cmt_seq = 8;
    @(negedge clk);
    chk("R9 free same cycle as commit", int'(free_total), 2);
    slot();
    @(negedge clk);
    chk("R9 free after commit", int'(free_total), 5);
    chk("R8 thr_free0", int'(thr_free[3:0]), 4);
    slot(); cmt_valid = 1; cmt_tid = 0; cmt_seq = 10;
    slot(); sq_valid = 1; sq_tid = 1; sq_seq = 0;
    slot();
    @(negedge clk);
    chk("R7 squash frees thread1", int'(free_total), 8);

    // R5 non-speculative hold
    dispatch(20, 0, 0, 1, 1, 0, 1);
    dispatch(21, 1, 0, 0, 1, 0, 1);
    expect_iss(21, 1, 0, cyc + 1);
    idle(3);
    slot(); rel_valid = 1; rel_tid = 0; rel_seq = 22;
    idle(3);
    slot(); rel_valid = 1; rel_tid = 0; rel_seq = 20;
    expect_iss(20, 0, 0, cyc + 1);
    idle(3);
    slot(); cmt_valid = 1; cmt_tid = 0; cmt_seq = 21;
    slot();
    @(negedge clk);
    chk("R6 free after commit", int'(free_total), 8);

    // R7 squash, including same-cycle block
    dispatch(40, 2, 0, 0, 0, 61, 1);
    dispatch(30, 0, 1, 0, 0, 60, 1);
    dispatch(31, 1, 1, 0, 0, 60, 1);
    dispatch(32, 2, 1, 0, 0, 60, 1);
    dispatch(33, 0, 1, 0, 1, 0, 1);
    slot(); sq_valid = 1; sq_tid = 1; sq_seq = 30;
    @(negedge clk);
    chk("R7 no issue in squash cycle", int'(iss_valid), 0);
    slot();
    @(negedge clk);
    chk("R7 free after squash", int'(free_total), 6);
    chk("R7 thr_free1", int'(thr_free[7:4]), 5);
    chk("R7 thr_free0 kept", int'(thr_free[3:0]), 5);
    slot(); wake_valid = 1; wake_tid = 1; wake_tag = 60;
    expect_iss(30, 0, 1, cyc + 1);
    idle(2);
    slot(); wake_valid = 1; wake_tid = 0; wake_tag = 61;
    expect_iss(40, 2, 0, cyc + 1);
    idle(2);
    slot(); cmt_valid = 1; cmt_tid = 0; cmt_seq = 255;
    slot(); cmt_valid = 1; cmt_tid = 1; cmt_seq = 255;
    slot();
    @(negedge clk);
    chk("R6 empty again", int'(free_total), 8);

    // R8 thread limit and total full, R9 reuse
    for (int k = 0; k < 6; k++) dispatch(100 + k, k % 3, 0, 0, 0, 200, 1);
    dispatch(106, 0, 0, 0, 0, 200, 0);
    chk("R8 thr_full0", int'(thr_full[0]), 1);
    dispatch(110, 1, 1, 0, 0, 201, 1);
    dispatch(111, 2, 1, 0, 0, 201, 1);
    dispatch(112, 0, 1, 0, 0, 201, 0);
    chk("R8 full_total", int'(full_total), 1);
    chk("R8 free_total zero", int'(free_total), 0);
    slot(); cmt_valid = 1; cmt_tid = 1; cmt_seq = 111;
    set_disp(120, 0, 1, 0, 1, 0);
    @(negedge clk);
    chk("R9 refused in commit cycle", int'(disp_accept), 0);
    dispatch(113, 1, 1, 0, 1, 0, 1);
    expect_iss(113, 1, 1, cyc + 1);
    slot(); wake_valid = 1; wake_tid = 0; wake_tag = 200;
    expect_iss(100, 0, 0, cyc + 1);
    expect_iss(101, 1, 0, cyc + 1);
    expect_iss(102, 2, 0, cyc + 2);
    expect_iss(103, 0, 0, cyc + 2);
    expect_iss(104, 1, 0, cyc + 3);
    expect_iss(105, 2, 0, cyc + 3);
    idle(5);
    slot(); cmt_valid = 1; cmt_tid = 0; cmt_seq = 255;
    slot(); cmt_valid = 1; cmt_tid = 1; cmt_seq = 255;
    idle(2);
    @(negedge clk);
    chk("R9 all freed", int'(free_total), 8);
    chk("R2 scoreboard drained", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 5000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected<5000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule